// File: doc/BRIEF.md
# Multicast Hash Filter Table

This block decides whether a received frame's multicast destination address should be accepted. The decision uses a 64-bit hash table held as two 32-bit words. For a 48-bit address it runs a reflected CRC-32 over the six address bytes, one byte per clock. The final CRC is inverted and then bit-reversed to form a 32-bit hash. The top six bits of that hash select a single table bit: the most significant bit selects the word and the next five bits select the bit within the word.

An operation begins with a start pulse and a mode flag. In insert mode the block sets the selected bit and leaves every other bit of the table as it was. In lookup mode it reports whether the selected bit is set, which means the frame passes the filter. Software can read and write each table word through a small register port, and can clear the whole table with one pulse. It normally does this while initialising, before any addresses are inserted.

Top module: `mhf_filter`

## Requirements
- R1: After reset both table words read 0, and busy_o, done_o and hit_o are low.
- R2: When done_o is high, hash_o equals the bit-reversed complement of a CRC-32 computed as follows. The CRC starts at all ones and uses the reflected polynomial 0xEDB88320. Bytes are taken in the order addr_i[47:40] first and addr_i[7:0] last, and each byte is taken least significant bit first. Bit reversal moves bit i to bit 31-i.
- R3: When start_i is accepted, busy_o is high for the next 6 cycles. done_o then goes high for exactly one cycle, 7 cycles after the accepting edge.
- R4: hash_o[31] selects the table word, where 0 is word 0 and 1 is word 1. hash_o[30:26] selects the bit position within that word.
- R5: An insert sets the selected table bit at the clock edge that ends the done cycle, and leaves all other table bits unchanged. Without an insert, a write or a clear, the table does not change.
- R6: In lookup mode, hit_o during the done cycle equals the selected table bit. hit_o is low at all other times, and a lookup never changes the table.
- R7: reg_we_i writes reg_wdata_i into the word chosen by reg_sel_i. reg_rdata_o shows the word chosen by reg_sel_i in the same cycle.
- R8: clear_i sets both words to 0 at the next edge. It overrides a register write and an insert made in the same cycle.
- R9: start_i is ignored while busy_o is high, and the operation already running completes unchanged.
- R10: If an insert and a register write target the same word in the same cycle, that word becomes the written value with the inserted bit ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation on addr_i |
| insert_i | input | 1 | Mode sampled with start_i: 1 means insert, 0 means lookup |
| addr_i | input | 48 | Destination address; addr_i[47:40] is the first byte |
| busy_o | output | 1 | Hash computation in progress |
| done_o | output | 1 | One-cycle strobe; hash_o and hit_o are valid |
| hit_o | output | 1 | Lookup result: the selected table bit is set |
| hash_o | output | 32 | Final hash value |
| reg_sel_i | input | 1 | Table word select for reads and writes |
| reg_we_i | input | 1 | Write strobe for the selected word |
| reg_wdata_i | input | 32 | Write data |
| clear_i | input | 1 | Clear both table words |
| reg_rdata_o | output | 32 | Selected table word |

## Verification
Several properties are checked on every cycle: the done strobe lasts one cycle and always follows the end of busy, hit_o appears only in lookup done cycles, a clear empties the table, an insert lands on the bit its hash selects, and the table holds its value when nothing writes it. The bench scenarios cover the rest: the hash value for specific addresses, the exact latency, the table contents after inserts and lookups, a start that is ignored while busy, and the write-and-insert and clear-and-insert collisions.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // one address byte, LSB first, reflected form
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY_REFL : 32'h0);
    end
    return c;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [8*ADDR_BYTES-1:0] addr_i,
  output logic                    accept_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [31:0]             hash_o
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int CNT_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       crc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q;

  assign accept_o = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      crc_q  <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        addr_q <= addr_i;
        crc_q  <= '1;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        crc_q  <= crc_step_byte(crc_q, addr_q[ADDR_W-1 -: 8]);
        addr_q <= addr_q << 8;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign hash_o = rev32(~crc_q);
endmodule

// File: rtl/mhf_index.sv
module mhf_index #(
  parameter int TABLE_WORDS = 2,
  parameter int WORD_W      = 32
) (
  input  logic [$clog2(TABLE_WORDS*WORD_W)-1:0] idx_i,
  output logic [$clog2(TABLE_WORDS)-1:0]        word_o,
  output logic [$clog2(WORD_W)-1:0]             bit_o
);
  localparam int IDX_W  = $clog2(TABLE_WORDS * WORD_W);
  localparam int WSEL_W = $clog2(TABLE_WORDS);
  localparam int BIT_W  = $clog2(WORD_W);

  assign word_o = idx_i[IDX_W-1 -: WSEL_W];
  assign bit_o  = idx_i[BIT_W-1:0];
endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int TABLE_WORDS = 2,
  parameter int WORD_W      = 32
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   clr_i,
  input  logic                                   wr_en_i,
  input  logic [$clog2(TABLE_WORDS)-1:0]         wr_sel_i,
  input  logic [WORD_W-1:0]                      wr_data_i,
  input  logic                                   ins_en_i,
  input  logic [$clog2(TABLE_WORDS)-1:0]         ins_word_i,
  input  logic [$clog2(WORD_W)-1:0]              ins_bit_i,
  output logic [TABLE_WORDS-1:0][WORD_W-1:0]     table_o
);
  logic [WORD_W-1:0] ins_mask;
  assign ins_mask = {{(WORD_W-1){1'b0}}, 1'b1} << ins_bit_i;

  for (genvar w = 0; w < TABLE_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q, base;
    logic              wr_hit, ins_hit;
    assign wr_hit  = wr_en_i  && (wr_sel_i   == w);
    assign ins_hit = ins_en_i && (ins_word_i == w);
    assign base    = wr_hit ? wr_data_i : word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q <= '0;
      else if (clr_i)   word_q <= '0;
      else              word_q <= base | (ins_hit ? ins_mask : '0);
    end
    assign table_o[w] = word_q;
  end
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES  = 6,
  parameter int TABLE_WORDS = 2,
  parameter int WORD_W      = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic                            insert_i,
  input  logic [8*ADDR_BYTES-1:0]         addr_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic                            hit_o,
  output logic [31:0]                     hash_o,
  input  logic [$clog2(TABLE_WORDS)-1:0]  reg_sel_i,
  input  logic                            reg_we_i,
  input  logic [WORD_W-1:0]               reg_wdata_i,
  input  logic                            clear_i,
  output logic [WORD_W-1:0]               reg_rdata_o
);
  localparam int IDX_W  = $clog2(TABLE_WORDS * WORD_W);
  localparam int WSEL_W = $clog2(TABLE_WORDS);
  localparam int BIT_W  = $clog2(WORD_W);

  logic                                accept;
  logic                                op_ins_q;
  logic [IDX_W-1:0]                    hash_idx;
  logic [WSEL_W-1:0]                   sel_word;
  logic [BIT_W-1:0]                    sel_bit;
  logic [TABLE_WORDS-1:0][WORD_W-1:0]  table_w;

  mhf_crc_engine #(.ADDR_BYTES(ADDR_BYTES)) u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .addr_i   (addr_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .hash_o   (hash_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     op_ins_q <= 1'b0;
    else if (accept) op_ins_q <= insert_i;
  end

  assign hash_idx = hash_o[31 -: IDX_W];

  mhf_index #(.TABLE_WORDS(TABLE_WORDS), .WORD_W(WORD_W)) u_idx (
    .idx_i  (hash_idx),
    .word_o (sel_word),
    .bit_o  (sel_bit)
  );

  mhf_table #(.TABLE_WORDS(TABLE_WORDS), .WORD_W(WORD_W)) u_tab (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clear_i),
    .wr_en_i    (reg_we_i),
    .wr_sel_i   (reg_sel_i),
    .wr_data_i  (reg_wdata_i),
    .ins_en_i   (done_o && op_ins_q),
    .ins_word_i (sel_word),
    .ins_bit_i  (sel_bit),
    .table_o    (table_w)
  );

  assign hit_o       = done_o && !op_ins_q && table_w[sel_word][sel_bit];
  assign reg_rdata_o = table_w[reg_sel_i];
endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk #(
  parameter int TABLE_WORDS = 2,
  parameter int WORD_W      = 32
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                busy_o,
  input logic                                done_o,
  input logic                                hit_o,
  input logic                                reg_we_i,
  input logic                                clear_i,
  input logic                                op_ins_q,
  input logic [$clog2(TABLE_WORDS*WORD_W)-1:0] hash_idx,
  input logic [TABLE_WORDS-1:0][WORD_W-1:0]  table_w
);
  localparam int IDX_W  = $clog2(TABLE_WORDS * WORD_W);
  localparam int WSEL_W = $clog2(TABLE_WORDS);
  localparam int BIT_W  = $clog2(WORD_W);

  logic [WSEL_W-1:0] c_word;
  logic [BIT_W-1:0]  c_bit;
  assign c_word = hash_idx[IDX_W-1 -: WSEL_W];
  assign c_bit  = hash_idx[BIT_W-1:0];

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R3
  AST_HIT_IN_LOOKUP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (done_o && !op_ins_q)); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (table_w == '0)); // R8
  AST_INSERT_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_ins_q && !clear_i) |=> table_w[$past(c_word)][$past(c_bit)]); // R5
  AST_TABLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(done_o && op_ins_q) && !reg_we_i && !clear_i) |=> $stable(table_w)); // R5
endmodule

bind mhf_filter mhf_filter_chk #(.TABLE_WORDS(TABLE_WORDS), .WORD_W(WORD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .hit_o    (hit_o),
  .reg_we_i (reg_we_i),
  .clear_i  (clear_i),
  .op_ins_q (op_ins_q),
  .hash_idx (hash_idx),
  .table_w  (table_w)
);

// File: tb/mhf_filter_tb.sv
module mhf_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, insert = 1'b0;
  logic [47:0] addr = '0;
  logic        busy, done, hit;
  logic [31:0] hash;
  logic        sel = 1'b0, we = 1'b0, clr = 1'b0;
  logic [31:0] wdata = '0, rdata;

  int checks = 0, fails = 0;
  logic [31:0] mtab [2];

  always #5 clk = ~clk;

  mhf_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .insert_i(insert), .addr_i(addr),
    .busy_o(busy), .done_o(done), .hit_o(hit), .hash_o(hash),
    .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wdata), .clear_i(clr), .reg_rdata_o(rdata)
  );

  function automatic logic [31:0] model_hash(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] h, r;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = a[47-8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ b[j];
        c = (c >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
      end
    end
    h = ~c;
    for (int i = 0; i < 32; i++) r[31-i] = h[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_word(input bit w, output logic [31:0] v);
    @(negedge clk); sel = w; #1; v = rdata;
  endtask

  // launch one operation, return values in the done cycle and latency
  task automatic run_op(input logic [47:0] a, input bit ins,
                        output logic [31:0] h, output bit ht, output int lat, output bit b1);
    @(negedge clk); start = 1'b1; insert = ins; addr = a;
    @(negedge clk); start = 1'b0; lat = 1; b1 = busy;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    h = hash; ht = hit;
  endtask

  task automatic model_ins(input logic [31:0] h);
    mtab[h[31]][h[30:26]] = 1'b1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(!busy && !done && !hit, "R1 outputs", {busy, done, hit}, 0);
    rd_word(0, v); chk(v == 0, "R1 word0", v, 0);
    rd_word(1, v); chk(v == 0, "R1 word1", v, 0);
  endtask

  task automatic t_lookup_empty;
    logic [47:0] pats [4] = '{48'h0100_5E00_0001, 48'hFFFF_FFFF_FFFF, 48'h3333_0000_0001, 48'h0000_0000_0000};
    logic [31:0] h; bit ht, b1; int lat;
    foreach (pats[i]) begin
      run_op(pats[i], 0, h, ht, lat, b1);
      chk(h == model_hash(pats[i]), "R2 hash", h, model_hash(pats[i]));
      chk(lat == 7 && b1, "R3 latency", lat, 7);
      chk(!ht, "R6 empty miss", ht, 0);
      @(negedge clk); chk(!done, "R3 done width", done, 0);
    end
  endtask

  task automatic t_insert_lookup;
    logic [47:0] a = 48'h0100_5E7F_00FB;
    logic [47:0] b = 48'h0100_5E00_00FC;
    logic [31:0] h, hb, v; bit ht, b1; int lat;
    run_op(a, 1, h, ht, lat, b1);
    chk(!ht, "R6 no hit on insert", ht, 0);
    model_ins(model_hash(a));
    rd_word(0, v); chk(v == mtab[0], "R4 R5 word0", v, mtab[0]);
    rd_word(1, v); chk(v == mtab[1], "R4 R5 word1", v, mtab[1]);
    run_op(a, 0, h, ht, lat, b1);
    chk(ht, "R6 hit", ht, 1);
    hb = model_hash(b);
    run_op(b, 0, h, ht, lat, b1);
    chk(ht == mtab[hb[31]][hb[30:26]], "R6 other", ht, mtab[hb[31]][hb[30:26]]);
    rd_word(0, v); chk(v == mtab[0], "R6 lookup no change w0", v, mtab[0]);
    rd_word(1, v); chk(v == mtab[1], "R6 lookup no change w1", v, mtab[1]);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    @(negedge clk); sel = 1; we = 1; wdata = 32'hA5A5_0F0F;
    @(negedge clk); we = 0; mtab[1] = 32'hA5A5_0F0F;
    rd_word(1, v); chk(v == mtab[1], "R7 write w1", v, mtab[1]);
    rd_word(0, v); chk(v == mtab[0], "R7 w0 untouched", v, mtab[0]);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    @(negedge clk); clr = 1; we = 1; sel = 0; wdata = 32'hFFFF_FFFF;
    @(negedge clk); clr = 0; we = 0; mtab[0] = 0; mtab[1] = 0;
    rd_word(0, v); chk(v == 0, "R8 clear w0", v, 0);
    rd_word(1, v); chk(v == 0, "R8 clear w1", v, 0);
  endtask

  task automatic t_busy_ignore;
    logic [47:0] a = 48'h0100_5E12_3456, b2 = 48'h0100_5EAB_CDEF;
    logic [31:0] v;
    int lat;
    @(negedge clk); start = 1; insert = 0; addr = a;
    @(negedge clk); insert = 1; addr = b2; lat = 1;
    @(negedge clk); start = 0; lat++;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    chk(lat == 7, "R9 latency kept", lat, 7);
    chk(hash == model_hash(a), "R9 first address", hash, model_hash(a));
    rd_word(0, v); chk(v == 0, "R9 no insert w0", v, 0);
    rd_word(1, v); chk(v == 0, "R9 no insert w1", v, 0);
  endtask

  task automatic t_collide;
    logic [47:0] a = 48'h0100_5E01_0203;
    logic [31:0] h = model_hash(a), v, exp;
    @(negedge clk); start = 1; insert = 1; addr = a;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    sel = h[31]; we = 1; wdata = 32'h0000_0000;
    @(negedge clk); we = 0;
    exp = 32'h1 << h[30:26];
    rd_word(h[31], v); chk(v == exp, "R10 write plus insert", v, exp);
    // clear wins over insert
    @(negedge clk); start = 1; insert = 1; addr = a;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    clr = 1;
    @(negedge clk); clr = 0;
    rd_word(h[31], v); chk(v == 0, "R8 clear over insert", v, 0);
  endtask

  initial begin
    mtab[0] = 0; mtab[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lookup_empty();
    t_insert_lookup();
    t_regs();
    t_clear();
    t_busy_ignore();
    t_collide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule